// File: doc/BRIEF.md
# Background Attribute Palette Pipeline

This block supplies the 2-bit palette select that goes with each background pixel of a tile-based video generator. It owns the 15-bit scroll address register. Once per 8-dot tile period it reads the attribute byte that covers the current tile from video memory. It picks the 2-bit field for the tile's quadrant, then passes that value through a pair of per-pixel shift registers. A 3-bit fine horizontal scroll value selects the tap on those shifters, so the palette stays in step with pixel data at any scroll offset, not only at multiples of 8.

The caller supplies the dot counter, a line qualifier and a background-enable bit. It can overwrite the scroll register at any dot. Video memory is reached through a simple read port with one cycle of latency. Pattern fetches and sprites are handled elsewhere.

Top module: `bgat_palette_unit`

## Requirements
- R1: While reset is held and at the first cycle after it, `scroll_v` is 0, `pal_sel` is 0 and `vram_rd` is 0.
- R2: The unit is active when `bg_enable` and `render_line` are both 1. While active, `vram_rd` is 1 exactly in cycles where `dot[2:0]` is 3.
- R3: During a read, `vram_addr` equals 0x23C0 | (v & 0x0C00) | ((v >> 4) & 0x38) | ((v >> 2) & 0x07), truncated to 14 bits, where v is `scroll_v` in that cycle.
- R4: The byte on `vram_rdata` in the cycle after a read is reduced to 2 bits using the quadrant {v[6], v[1]} captured with the read: 00 takes bits [1:0], 01 takes [3:2], 10 takes [5:4] and 11 takes [7:6].
- R5: At the end of an active cycle whose `dot` is a nonzero multiple of 8, coarse X (v[4:0]) increases by one. Dot 0 causes no increment, and the other bits of v are unchanged.
- R6: If coarse X is 31 at such an increment, it becomes 0 and v[10] inverts. No other bit changes.
- R7: When `v_load` is 1, `scroll_v` takes `v_load_val` at the end of that cycle. This overrides any increment in the same cycle.
- R8: At each increment dot the most recently reduced 2-bit value is loaded into a feed latch. Both shifters move one place on every active cycle, shifting in the latch bits. Counting active cycles from 0, `pal_sel` during active cycle n equals the latch contents after active cycle n − 9 + `fine_x`, and 0 if that index is negative.
- R9: While not active, no read is issued, `scroll_v` changes only by `v_load`, and `pal_sel`, the shifters and the feed latch hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bg_enable | input | 1 | Background rendering enabled |
| render_line | input | 1 | Current line is visible or pre-render |
| dot | input | 9 | Dot index within the line |
| fine_x | input | 3 | Fine horizontal scroll |
| v_load | input | 1 | Overwrite the scroll register this cycle |
| v_load_val | input | 15 | Value written by `v_load` |
| scroll_v | output | 15 | Scroll address register |
| vram_rd | output | 1 | Attribute read request |
| vram_addr | output | 14 | Attribute read address |
| vram_rdata | input | 8 | Read data, valid the cycle after the request |
| pal_sel | output | 2 | Palette select for the current pixel |

## Verification
The assertions check on every cycle how the scroll register moves: the coarse-X step, the wrap with its nametable toggle, the priority of a load, and freezing while inactive. They also check that each shifter advances by one place per active dot, that everything holds while inactive, and that no read occurs outside active cycles. Only the bench scenarios can show the end-to-end palette values. Those depend on the attribute address formula, the quadrant choice from the returned byte, and the exact dot at which a fetched value surfaces at each fine-X setting. The bench covers these across wrap, mid-line loads, disabled stretches and a non-rendering line.

// File: rtl/bgat_pkg.sv
package bgat_pkg;
    localparam int SCROLL_W   = 15;
    localparam int VRAM_AW    = 14;
    localparam int VRAM_DW    = 8;
    localparam int DOT_W      = 9;
    localparam int TILE_PX    = 8;
    localparam int PAL_W      = 2;
    localparam int COARSE_W   = 5;
    localparam int NT_X_BIT   = 10;
    localparam int QUAD_X_BIT = 1;
    localparam int QUAD_Y_BIT = 6;
    localparam int FETCH_PH   = 3;
    localparam logic [SCROLL_W-1:0] ATTR_BASE = 15'h23C0;
    localparam logic [SCROLL_W-1:0] NT_MASK   = 15'h0C00;
    localparam logic [SCROLL_W-1:0] ROW_MASK  = 15'h0038;
    localparam logic [SCROLL_W-1:0] COL_MASK  = 15'h0007;

    // Quadrant q selects the 2-bit field starting at bit 2*q.
    function automatic logic [PAL_W-1:0] quad_pick(input logic [VRAM_DW-1:0] b,
                                                   input logic [1:0] q);
        logic [VRAM_DW-1:0] s;
        s = b >> {q, 1'b0};
        return s[PAL_W-1:0];
    endfunction
endpackage

// File: rtl/bgat_scroll_reg.sv
module bgat_scroll_reg
    import bgat_pkg::*;
#(
    parameter int V_W    = SCROLL_W,
    parameter int CX_W   = COARSE_W,
    parameter int NT_BIT = NT_X_BIT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           load,
    input  logic [V_W-1:0] load_val,
    output logic [V_W-1:0] v_o
);
    typedef struct packed {
        logic [V_W-1:0] v;
    } scroll_st_t;

    scroll_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.v = load_val;
        end else if (step) begin
            if (&s_q.v[CX_W-1:0]) begin
                s_d.v[CX_W-1:0] = '0;
                s_d.v[NT_BIT]   = ~s_q.v[NT_BIT];
            end else begin
                s_d.v[CX_W-1:0] = s_q.v[CX_W-1:0] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign v_o = s_q.v;

    AST_CX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> s_q.v[CX_W-1:0] == CX_W'($past(s_q.v[CX_W-1:0]) + 1'b1)); // R5
    AST_NT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && (&s_q.v[CX_W-1:0])) |=> s_q.v[NT_BIT] != $past(s_q.v[NT_BIT])); // R6
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> s_q.v == $past(load_val)); // R7
    AST_V_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(s_q.v)); // R9
endmodule

// File: rtl/bgat_attr_fetch.sv
module bgat_attr_fetch
    import bgat_pkg::*;
#(
    parameter int V_W = SCROLL_W,
    parameter int AW  = VRAM_AW,
    parameter int DW  = VRAM_DW,
    parameter int PW  = PAL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fetch_slot,
    input  logic [V_W-1:0] v,
    output logic           rd_o,
    output logic [AW-1:0]  addr_o,
    input  logic [DW-1:0]  rdata_i,
    output logic [PW-1:0]  pal_o
);
    typedef struct packed {
        logic          pend;
        logic [1:0]    quad;
        logic [PW-1:0] pal;
    } fetch_st_t;

    fetch_st_t s_d, s_q;
    logic [V_W-1:0] addr_full;

    always_comb begin
        addr_full = ATTR_BASE | (v & NT_MASK) | ((v >> 4) & ROW_MASK) | ((v >> 2) & COL_MASK);
        addr_o    = addr_full[AW-1:0];
        rd_o      = fetch_slot;
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = fetch_slot;
        if (fetch_slot) begin
            s_d.quad = {v[QUAD_Y_BIT], v[QUAD_X_BIT]};
        end
        if (s_q.pend) begin
            s_d.pal = quad_pick(rdata_i, s_q.quad);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pal_o = s_q.pal;

    AST_PAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.pend |=> $stable(s_q.pal)); // R4
    AST_PEND_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> s_q.pend); // R2
endmodule

// File: rtl/bgat_pal_shift.sv
module bgat_pal_shift
    import bgat_pkg::*;
#(
    parameter int SH_W = TILE_PX,
    parameter int PW   = PAL_W,
    localparam int FX_W = $clog2(SH_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic            boundary,
    input  logic [PW-1:0]   pal_in,
    input  logic [FX_W-1:0] fine_x,
    output logic [PW-1:0]   pal_sel
);
    localparam logic [FX_W-1:0] TOP_TAP = FX_W'(SH_W - 1);

    typedef struct packed {
        logic [PW-1:0]            feed;
        logic [PW-1:0][SH_W-1:0]  sh;
    } shift_st_t;

    shift_st_t s_d, s_q;
    logic [FX_W-1:0] tap;

    always_comb begin
        s_d = s_q;
        if (active) begin
            for (int p = 0; p < PW; p++) begin
                s_d.sh[p] = {s_q.sh[p][SH_W-2:0], s_q.feed[p]};
            end
        end
        if (boundary) begin
            s_d.feed = pal_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tap = TOP_TAP - fine_x;

    for (genvar p = 0; p < PW; p++) begin : g_plane
        assign pal_sel[p] = s_q.sh[p][tap];

        AST_SHIFT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
            active |=> s_q.sh[p][SH_W-1:1] == $past(s_q.sh[p][SH_W-2:0])); // R8
    end

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(s_q.sh) && $stable(s_q.feed))); // R9
endmodule

// File: rtl/bgat_palette_unit.sv
module bgat_palette_unit
    import bgat_pkg::*;
#(
    parameter int V_W  = SCROLL_W,
    parameter int AW   = VRAM_AW,
    parameter int DW   = VRAM_DW,
    parameter int DW_D = DOT_W,
    parameter int TW   = TILE_PX,
    parameter int PW   = PAL_W,
    localparam int FX_W    = $clog2(TW),
    localparam int TILE_LG = $clog2(TW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bg_enable,
    input  logic            render_line,
    input  logic [DW_D-1:0] dot,
    input  logic [FX_W-1:0] fine_x,
    input  logic            v_load,
    input  logic [V_W-1:0]  v_load_val,
    output logic [V_W-1:0]  scroll_v,
    output logic            vram_rd,
    output logic [AW-1:0]   vram_addr,
    input  logic [DW-1:0]   vram_rdata,
    output logic [PW-1:0]   pal_sel
);
    logic               active;
    logic [TILE_LG-1:0] phase;
    logic               boundary;
    logic               fetch_slot;
    logic [PW-1:0]      pal_fetched;

    always_comb begin
        active     = bg_enable & render_line;
        phase      = dot[TILE_LG-1:0];
        boundary   = active && (phase == '0) && (dot != '0);
        fetch_slot = active && (phase == TILE_LG'(FETCH_PH));
    end

    bgat_scroll_reg #(.V_W(V_W)) u_scroll (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (boundary),
        .load     (v_load),
        .load_val (v_load_val),
        .v_o      (scroll_v)
    );

    bgat_attr_fetch #(.V_W(V_W), .AW(AW), .DW(DW), .PW(PW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_slot (fetch_slot),
        .v          (scroll_v),
        .rd_o       (vram_rd),
        .addr_o     (vram_addr),
        .rdata_i    (vram_rdata),
        .pal_o      (pal_fetched)
    );

    bgat_pal_shift #(.SH_W(TW), .PW(PW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .boundary (boundary),
        .pal_in   (pal_fetched),
        .fine_x   (fine_x),
        .pal_sel  (pal_sel)
    );

    AST_FETCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !(bg_enable && render_line) |-> !vram_rd); // R9
    AST_DOT0_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dot == '0 && !v_load) |=> $stable(scroll_v)); // R5
endmodule

// File: tb/bgat_palette_unit_tb_top.sv
`timescale 1ns/1ps
module bgat_palette_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bg_enable = 1'b0;
    logic        render_line = 1'b0;
    logic [8:0]  dot = '0;
    logic [2:0]  fine_x = '0;
    logic        v_load = 1'b0;
    logic [14:0] v_load_val = '0;
    logic [14:0] scroll_v;
    logic        vram_rd;
    logic [13:0] vram_addr;
    logic [7:0]  vram_rdata = '0;
    logic [1:0]  pal_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bgat_palette_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bg_enable(bg_enable), .render_line(render_line),
        .dot(dot), .fine_x(fine_x), .v_load(v_load), .v_load_val(v_load_val),
        .scroll_v(scroll_v), .vram_rd(vram_rd), .vram_addr(vram_addr),
        .vram_rdata(vram_rdata), .pal_sel(pal_sel)
    );

    function automatic logic [7:0] mem_f(input logic [13:0] a);
        return 8'(a[7:0] * 8'd157) + 8'(a[13:8]);
    endfunction

    always @(posedge clk) vram_rdata <= mem_f(vram_addr);

    // R4 quadrant table
    function automatic logic [1:0] pick(input logic [7:0] b, input logic [1:0] q);
        case (q)
            2'b00:   return b[1:0];
            2'b01:   return b[3:2];
            2'b10:   return b[5:4];
            default: return b[7:6];
        endcase
    endfunction

    typedef struct {
        logic [1:0]  pal;
        logic        rd;
        logic [13:0] addr;
        logic [14:0] v;
        string       ptag;
        string       rtag;
        string       vtag;
    } exp_t;

    exp_t sb[$];

    // bench model state
    logic [14:0] m_v = '0;
    logic        m_pend = 1'b0;
    logic [13:0] m_paddr = '0;
    logic [1:0]  m_quad = '0;
    logic [1:0]  m_cap = '0;
    logic [1:0]  m_latch = '0;
    int          n_act = 0;
    logic [1:0]  lat_hist [0:16383];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input bit en, input bit line, input int d, input int fx,
                         input bit ld, input logic [14:0] ldv);
        exp_t e;
        bit act, bnd, rd;
        int idx;
        logic [13:0] a;
        logic [1:0] cap_n;
        @(negedge clk);
        bg_enable = en; render_line = line; dot = 9'(d); fine_x = 3'(fx);
        v_load = ld; v_load_val = ldv;
        act = en && line;
        rd  = act && (d % 8 == 3);
        bnd = act && (d % 8 == 0) && (d != 0);
        a = 14'(15'h23C0 | (m_v & 15'h0C00) | ((m_v >> 4) & 15'h0038) | ((m_v >> 2) & 15'h0007));
        idx = n_act - 9 + fx;
        e.pal  = (idx >= 0) ? lat_hist[idx] : 2'b00;
        e.rd   = rd;
        e.addr = a;
        e.v    = m_v;
        e.ptag = act ? "R8 quadrant R4" : "R9";
        e.rtag = act ? "R2" : "R9";
        e.vtag = act ? "R5" : "R9";
        sb.push_back(e);
        // advance model across the coming edge
        cap_n = m_pend ? pick(mem_f(m_paddr), m_quad) : m_cap;
        if (bnd) m_latch = m_cap;
        m_cap = cap_n;
        m_pend = rd;
        if (rd) begin
            m_paddr = a;
            m_quad  = {m_v[6], m_v[1]};
        end
        if (ld) m_v = ldv;
        else if (bnd) begin
            if (m_v[4:0] == 5'd31) begin
                m_v[4:0] = 5'd0;
                m_v[10]  = ~m_v[10];
            end else m_v[4:0] = m_v[4:0] + 5'd1;
        end
        if (act) begin
            lat_hist[n_act] = m_latch;
            n_act++;
        end
    endtask

    // R6 and R7 are tagged on the scroll check of the following cycle
    string next_vtag = "";
    always @(negedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.ptag, 32'(pal_sel), 32'(e.pal));
            chk(e.rtag, 32'(vram_rd), 32'(e.rd));
            if (e.rd) chk("R3", 32'(vram_addr), 32'(e.addr));
            chk((next_vtag != "") ? next_vtag : e.vtag, 32'(scroll_v), 32'(e.v));
            next_vtag = "";
            if (v_load) next_vtag = "R7";
            else if (bg_enable && render_line && dot[2:0] == 3'd0 && dot != 9'd0
                     && scroll_v[4:0] == 5'd31) next_vtag = "R6";
        end
    end

    task automatic run_line(input bit line_on, input int fx,
                            input int ld_dot, input logic [14:0] ld_val,
                            input int off_lo, input int off_hi,
                            input int ld2_dot, input logic [14:0] ld2_val);
        for (int d = 0; d < 88; d++) begin
            bit en;
            bit ld;
            logic [14:0] lv;
            en = !(d >= off_lo && d <= off_hi);
            ld = (d == ld_dot) || (d == ld2_dot);
            lv = (d == ld2_dot) ? ld2_val : ld_val;
            drive(en, line_on, d, fx, ld, lv);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state while reset is held
        chk("R1", 32'(scroll_v), 32'h0);
        chk("R1", 32'(pal_sel), 32'h0);
        chk("R1", 32'(vram_rd), 32'h0);
        rst_n = 1'b1;
        // first cycle after reset, inactive: R1 values expected by the model
        drive(1'b0, 1'b0, 0, 0, 1'b0, 15'h0);
        run_line(1'b1, 0, 0, 15'h001C, -1, -1, -1, 15'h0);   // wrap 31 -> 0, R6
        run_line(1'b1, 5, 0, 15'h2C4A, -1, -1, -1, 15'h0);   // lower quadrants
        run_line(1'b1, 3, 0, 15'h1045, 30, 45, -1, 15'h0);   // disabled stretch, R9
        run_line(1'b0, 2, -1, 15'h0, -1, -1, -1, 15'h0);     // non-rendering line, R9
        run_line(1'b1, 7, 0, 15'h07DE, -1, -1, 24, 15'h0123); // load at boundary, R7
        run_line(1'b1, 1, 0, 15'h035F, -1, -1, 13, 15'h0A11); // mid-tile load
        run_line(1'b1, 4, -1, 15'h0, -1, -1, -1, 15'h0);
        repeat (3) @(negedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule